// File: doc/BRIEF.md
# Peripheral Bus Repeater Port

This block controls eight external pins that sit beside a microcontroller's demultiplexed data bus. When the repeater is switched on and the current data-cycle address falls inside one of two programmable windows, the port becomes a bidirectional buffer. A write strobe drives the pins from the processor's outgoing data. A read strobe returns the pin levels on the processor's incoming data lane. Cycles marked as code fetches never open the buffer. Outside the buffered condition, the pins behave as plain general-purpose I/O, driven from a direction register and an output data register.

Each window has an inclusive 16-bit lower and upper bound, an 8-bit page value and a control byte. The control byte holds a window-enable bit and a page-match enable. The two window hits are ORed together. The strobes are active low. If both strobes are asserted during a buffered cycle, nothing is driven and a sticky error flag latches. Configuration is written through a simple byte-wide register port.

Top module: `rpt_port`

## Requirements
- R1: After reset every configuration register is zero. Therefore `pin_oe`=0, `pin_out`=0, `cpu_din_oe`=0, `cpu_din`=0 and `strobe_err`=0.
- R2: While the buffer is inactive, `pin_oe` equals the direction register (cfg address 1) and `pin_out` equals the output register (cfg address 2).
- R3: Window n (n=0,1) sits at cfg base 4+6n. The offsets are +0 low[7:0], +1 low[15:8], +2 high[7:0], +3 high[15:8], +4 page, +5 control. Control bit0 enables the window. The window hits when low <= `cpu_addr` <= high, with both bounds inclusive.
- R4: When control bit1 of a window is set, that window hits only if `cpu_page` equals its page register.
- R5: The buffer qualifier is the OR of the two window hits, so either window alone can open it.
- R6: The buffer can be active only while bit7 of the mode register (cfg address 0) is 1.
- R7: When `code_fetch_n` is 0, the buffer is inactive and the pins follow R2.
- R8: In a buffered write (`cpu_wr_n`=0, `cpu_rd_n`=1), all eight `pin_oe` bits are 1 and `pin_out` equals `cpu_dout`. In that cycle `cpu_din_oe` is 0.
- R9: In a buffered read (`cpu_rd_n`=0, `cpu_wr_n`=1), `cpu_din` equals `pin_in`, `cpu_din_oe` is 1 and `pin_oe` is 0.
- R10: In a buffered cycle with neither strobe low, `pin_oe` and `cpu_din_oe` are both 0.
- R11: In a buffered cycle with both strobes low, neither direction drives. `strobe_err` becomes 1 after the next clock edge and stays 1 until reset.
- R12: A configuration write takes effect only after the rising clock edge at which `cfg_we` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write byte |
| cpu_addr | input | 16 | Current bus address |
| cpu_page | input | 8 | Current memory page number |
| code_fetch_n | input | 1 | Low during code-fetch cycles |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_dout | input | 8 | Data from processor (write data) |
| cpu_din | output | 8 | Data to processor (read data) |
| cpu_din_oe | output | 1 | Enable for the processor's read-data lane |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Per-pin output enables |
| strobe_err | output | 1 | Sticky flag for simultaneous strobes |

## Verification
The assertions check several properties on every cycle. The port never drives both directions at once. Code fetches and strobe clashes never enable read data. The error flag sets after a clash and never clears without reset. Only the bench scenarios can show the rest: the exact inclusive window edges, page gating, the OR of the two windows, the mode-bit gating and the register map itself. It takes specific address, page and configuration patterns to separate correct from off-by-one or swapped behaviour.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 16;
  localparam int PAGE_W     = 8;
  localparam int NUM_WIN    = 2;
  localparam int CFG_AW     = 4;
  localparam int REG_MODE   = 0;
  localparam int REG_DIR    = 1;
  localparam int REG_OUT    = 2;
  localparam int WIN_BASE   = 4;
  localparam int WIN_STRIDE = 6;
  localparam int MODE_EN_BIT = 7;

  typedef struct packed {
    logic              en;
    logic              pg_en;
    logic [PAGE_W-1:0] page;
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } win_cfg_t;
endpackage

// File: rtl/rpt_regs.sv
module rpt_regs
  import rpt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [DATA_W-1:0]             cfg_wdata,
  output logic                          mode_en,
  output logic [DATA_W-1:0]             gpio_dir,
  output logic [DATA_W-1:0]             gpio_out,
  output win_cfg_t [NUM_WIN-1:0]        win_cfg
);
  logic [DATA_W-1:0]      mode_q, mode_d;
  logic [DATA_W-1:0]      dir_q, dir_d, out_q, out_d;
  win_cfg_t [NUM_WIN-1:0] win_q, win_d;

  function automatic logic hit_reg(input logic [CFG_AW-1:0] a, input int idx);
    return a == CFG_AW'(idx);
  endfunction

  always_comb begin
    mode_d = mode_q;
    dir_d  = dir_q;
    out_d  = out_q;
    win_d  = win_q;
    if (cfg_we) begin
      if (hit_reg(cfg_addr, REG_MODE)) mode_d = cfg_wdata;
      if (hit_reg(cfg_addr, REG_DIR))  dir_d  = cfg_wdata;
      if (hit_reg(cfg_addr, REG_OUT))  out_d  = cfg_wdata;
      for (int w = 0; w < NUM_WIN; w++) begin
        if (hit_reg(cfg_addr, WIN_BASE + w*WIN_STRIDE + 0)) win_d[w].lo[7:0]  = cfg_wdata;
        if (hit_reg(cfg_addr, WIN_BASE + w*WIN_STRIDE + 1)) win_d[w].lo[15:8] = cfg_wdata;
        if (hit_reg(cfg_addr, WIN_BASE + w*WIN_STRIDE + 2)) win_d[w].hi[7:0]  = cfg_wdata;
        if (hit_reg(cfg_addr, WIN_BASE + w*WIN_STRIDE + 3)) win_d[w].hi[15:8] = cfg_wdata;
        if (hit_reg(cfg_addr, WIN_BASE + w*WIN_STRIDE + 4)) win_d[w].page     = cfg_wdata;
        if (hit_reg(cfg_addr, WIN_BASE + w*WIN_STRIDE + 5)) begin
          win_d[w].en    = cfg_wdata[0];
          win_d[w].pg_en = cfg_wdata[1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      win_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= mode_d;
      dir_q  <= dir_d;
      out_q  <= out_d;
      win_q  <= win_d;
    end
  end

  assign mode_en  = mode_q[MODE_EN_BIT];
  assign gpio_dir = dir_q;
  assign gpio_out = out_q;
  assign win_cfg  = win_q;

  // R12: no register changes without a sampled write
  a_r12_hold_without_we: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_q) && $stable(dir_q) && $stable(out_q));
endmodule

// File: rtl/rpt_window.sv
module rpt_window
  import rpt_pkg::*;
(
  input  win_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  output logic              hit
);
  logic in_range, page_ok;
  always_comb begin
    in_range = (addr >= cfg.lo) && (addr <= cfg.hi);
    page_ok  = !cfg.pg_en || (page == cfg.page);
    hit      = cfg.en && in_range && page_ok;
  end
endmodule

// File: rtl/rpt_datapath.sv
module rpt_datapath
  import rpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_en,
  input  logic              sel_any,
  input  logic              code_fetch_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [DATA_W-1:0] cpu_dout,
  input  logic [DATA_W-1:0] pin_in,
  input  logic [DATA_W-1:0] gpio_dir,
  input  logic [DATA_W-1:0] gpio_out,
  output logic [DATA_W-1:0] cpu_din,
  output logic              cpu_din_oe,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              strobe_err
);
  logic active, wr_go, rd_go, clash;
  logic err_q, err_d;

  always_comb begin
    active = mode_en && code_fetch_n && sel_any;
    wr_go  = active && !cpu_wr_n &&  cpu_rd_n;
    rd_go  = active && !cpu_rd_n &&  cpu_wr_n;
    clash  = active && !cpu_rd_n && !cpu_wr_n;
    pin_oe     = active ? {DATA_W{wr_go}} : gpio_dir;
    pin_out    = active ? cpu_dout : gpio_out;
    cpu_din    = rd_go ? pin_in : '0;
    cpu_din_oe = rd_go;
    err_d      = err_q | clash;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (clash) err_q <= err_d;
  end

  assign strobe_err = err_q;

  a_r9_single_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_din_oe && (|pin_oe)));
  a_r7_fetch_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    !code_fetch_n |-> !cpu_din_oe);
  a_r11_clash_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_rd_n && !cpu_wr_n) |-> !cpu_din_oe);
  a_r11_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> strobe_err);
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |=> strobe_err);
  a_r6_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !cpu_din_oe);
endmodule

// File: rtl/rpt_port.sv
module rpt_port
  import rpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [PAGE_W-1:0] cpu_page,
  input  logic              code_fetch_n,
  input  logic              cpu_rd_n,
  input  logic              cpu_wr_n,
  input  logic [DATA_W-1:0] cpu_dout,
  output logic [DATA_W-1:0] cpu_din,
  output logic              cpu_din_oe,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe,
  output logic              strobe_err
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                   mode_en;
  logic [DATA_W-1:0]      gpio_dir, gpio_out;
  win_cfg_t [NUM_WIN-1:0] win_cfg;
  logic [NUM_WIN-1:0]     win_hit;

  rpt_regs u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mode_en(mode_en), .gpio_dir(gpio_dir), .gpio_out(gpio_out),
    .win_cfg(win_cfg)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    rpt_window u_win (
      .cfg(win_cfg[g]), .addr(cpu_addr), .page(cpu_page), .hit(win_hit[g])
    );
  end

  rpt_datapath u_dp (
    .clk(clk), .rst_n(rst_int_n),
    .mode_en(mode_en), .sel_any(|win_hit), .code_fetch_n(code_fetch_n),
    .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cpu_dout(cpu_dout),
    .pin_in(pin_in), .gpio_dir(gpio_dir), .gpio_out(gpio_out),
    .cpu_din(cpu_din), .cpu_din_oe(cpu_din_oe),
    .pin_out(pin_out), .pin_oe(pin_oe), .strobe_err(strobe_err)
  );
endmodule

// File: tb/rpt_port_bench.sv
module rpt_port_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [3:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [15:0] cpu_addr;
  logic [7:0] cpu_page;
  logic       code_fetch_n, cpu_rd_n, cpu_wr_n;
  logic [7:0] cpu_dout, cpu_din, pin_in, pin_out, pin_oe;
  logic       cpu_din_oe, strobe_err;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpt_port u_rpt_port (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr), .cpu_page(cpu_page),
    .code_fetch_n(code_fetch_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
    .cpu_dout(cpu_dout), .cpu_din(cpu_din), .cpu_din_oe(cpu_din_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .strobe_err(strobe_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on falling edge, settle, sample combinational outputs
  task automatic bus(input logic [15:0] a, input logic [7:0] pg, input logic fn,
                     input logic rd, input logic wr);
    @(negedge clk);
    cpu_addr = a; cpu_page = pg; code_fetch_n = fn; cpu_rd_n = rd; cpu_wr_n = wr;
    #1;
  endtask

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    cpu_addr = '0; cpu_page = '0; code_fetch_n = 1'b1; cpu_rd_n = 1'b1;
    cpu_wr_n = 1'b1; cpu_dout = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 cpu_din_oe", cpu_din_oe, 0);
    chk("R1 cpu_din", cpu_din, 0);
    chk("R1 strobe_err", strobe_err, 0);
  endtask

  task automatic t_gpio();
    wreg(4'd1, 8'h0F);
    wreg(4'd2, 8'hA5);
    bus(16'h1000, 8'h00, 1, 1, 0);
    chk("R2 gpio dir", pin_oe, 8'h0F);
    chk("R2 gpio out", pin_out, 8'hA5);
  endtask

  task automatic t_window0();
    // window0: 0x1000..0x10FF, enabled, no page match
    wreg(4'd4, 8'h00); wreg(4'd5, 8'h10);
    wreg(4'd6, 8'hFF); wreg(4'd7, 8'h10);
    wreg(4'd9, 8'h01);
    // R12: mode write not visible before its edge
    cpu_dout = 8'h5A;
    bus(16'h1000, 8'h00, 1, 1, 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h80;
    #1;
    chk("R12 before edge", pin_oe, 8'h0F);
    @(negedge clk);
    cfg_we = 1'b0; #1;
    chk("R12 after edge", pin_oe, 8'hFF);
    chk("R8 write data", pin_out, 8'h5A);
    chk("R8 no read", cpu_din_oe, 0);
    bus(16'h10FF, 8'h00, 1, 1, 0);
    chk("R3 upper bound", pin_oe, 8'hFF);
    bus(16'h0FFF, 8'h00, 1, 1, 0);
    chk("R3 below lower", pin_oe, 8'h0F);
    bus(16'h1100, 8'h00, 1, 1, 0);
    chk("R3 above upper", pin_out, 8'hA5);
  endtask

  task automatic t_read_idle();
    pin_in = 8'h3C;
    bus(16'h1080, 8'h00, 1, 0, 1);
    chk("R9 read data", cpu_din, 8'h3C);
    chk("R9 read oe", cpu_din_oe, 1);
    chk("R9 pins off", pin_oe, 8'h00);
    bus(16'h1080, 8'h00, 1, 1, 1);
    chk("R10 idle pins", pin_oe, 8'h00);
    chk("R10 idle read", cpu_din_oe, 0);
  endtask

  task automatic t_fetch();
    bus(16'h1080, 8'h00, 0, 0, 1);
    chk("R7 fetch no read", cpu_din_oe, 0);
    chk("R7 fetch gpio", pin_oe, 8'h0F);
  endtask

  task automatic t_page_or();
    // window1: 0x8000..0x8FFF, page 3, page match on
    wreg(4'd10, 8'h00); wreg(4'd11, 8'h80);
    wreg(4'd12, 8'hFF); wreg(4'd13, 8'h8F);
    wreg(4'd14, 8'h03); wreg(4'd15, 8'h03);
    bus(16'h8100, 8'h03, 1, 1, 0);
    chk("R5 window1 opens", pin_oe, 8'hFF);
    bus(16'h8100, 8'h02, 1, 1, 0);
    chk("R4 page mismatch", pin_oe, 8'h0F);
    bus(16'h1010, 8'h02, 1, 1, 0);
    chk("R5 window0 still opens", pin_oe, 8'hFF);
  endtask

  task automatic t_disable();
    wreg(4'd0, 8'h7F);
    bus(16'h1010, 8'h00, 1, 0, 1);
    chk("R6 disabled read", cpu_din_oe, 0);
    chk("R6 disabled gpio", pin_oe, 8'h0F);
    wreg(4'd0, 8'h80);
  endtask

  task automatic t_clash();
    bus(16'h1010, 8'h00, 1, 0, 0);
    chk("R11 clash no pins", pin_oe, 8'h00);
    chk("R11 clash no read", cpu_din_oe, 0);
    chk("R11 err before edge", strobe_err, 0);
    @(posedge clk); #1;
    chk("R11 err set", strobe_err, 1);
    bus(16'h1010, 8'h00, 1, 1, 1);
    repeat (3) @(negedge clk);
    chk("R11 err sticky", strobe_err, 1);
    do_reset();
    chk("R1 err cleared", strobe_err, 0);
    chk("R1 mode cleared", pin_oe, 8'h00);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_gpio();
    t_window0();
    t_read_idle();
    t_fetch();
    t_page_or();
    t_disable();
    t_clash();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule